// File: doc/BRIEF.md
# Interrupt Group Priority Mask Unit

This block keeps the binary-point settings that split an 8-bit interrupt priority into a group part and a subpriority part. There are three settings: one for group 0, one for secure group 1 and one for non-secure group 1. From these it produces a mask that keeps only the group-priority bits. A lookup port takes an interrupt group, a pending priority and the running priority. One cycle later it returns the mask, the masked pending priority and a flag that says whether the pending interrupt may preempt.

Two control bits, one per security state, make group 1 lookups use the group 0 setting and the group 0 rules instead of their own. The non-secure group 1 setting counts from one less than the others. Its smallest legal value is 1. A write below a register's floor is raised to that floor.

A software-style write/read port reaches the three settings and the control word. A parameter picks between two reset profiles: the physical one and the virtual one.

Top module: `gpm_unit`

## Requirements
- R1: For group code 0, and also for the unused code 3, with group 0 setting n, the mask keeps bits [7:n+1] and clears the rest. At n=7 the mask is 8'h00.
- R2: For group code 1 (secure group 1), when its shared bit is clear, the mask follows the R1 rule using the secure group 1 setting.
- R3: For group code 2 (non-secure group 1), when its shared bit is clear, with setting n the mask keeps bits [7:n]. At n=7 only bit 7 is kept.
- R4: Control word bit 0 set makes code-1 lookups use the group 0 setting with the R1 rule. Control word bit 1 set does the same for code-2 lookups. Each bit has no effect on the other group.
- R5: A write keeps only wr_data[2:0] and ignores the upper bits. A stored setting below the register's floor is raised to the floor. The floor is 1 for non-secure group 1 and 0 for the other two settings. Select codes are: 0 = group 0, 1 = secure group 1, 2 = non-secure group 1, 3 = control word (bits 1:0).
- R6: preempt is 1 exactly when (lk_prio & mask) < (run_prio & mask). gp_prio carries lk_prio & mask.
- R7: With the physical reset, the settings reset to 0, 0 and 1 and the control word to 0. With the virtual reset, group 0 resets to 0 and both group 1 settings reset to 1.
- R8: Lookup outputs appear one cycle after their inputs. A write changes lookup results only from the cycle after it is captured.
- R9: rd_data appears one cycle after rd_sel. It holds the selected value zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register written (R5 codes) |
| wr_data | input | 8 | Write value |
| rd_sel | input | 2 | Register read (R5 codes) |
| rd_data | output | 8 | Registered read value |
| lk_group | input | 2 | Lookup group code |
| lk_prio | input | 8 | Pending priority |
| run_prio | input | 8 | Running priority |
| gp_mask | output | 8 | Registered group priority mask |
| gp_prio | output | 8 | Registered masked pending priority |
| preempt | output | 1 | Registered preemption flag |

## Verification
The bench targets the off-by-one of the non-secure group. A design that treats it like group 0 returns a mask one bit short, and at setting 7 it returns an empty mask instead of bit 7 alone. The bench crosses each shared bit with each group, so a swapped or global shared bit redirects the wrong group.

Writes of zero, and writes whose upper bits are set, catch clamping done before truncation or not done at all. Equal masked priorities check that preemption is strict. A write in the same cycle as a lookup catches a bypass that makes the new setting visible one cycle too early.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_RSV  = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    SEL_BP0   = 2'd0,
    SEL_BP1S  = 2'd1,
    SEL_BP1NS = 2'd2,
    SEL_CTRL  = 2'd3
  } sel_e;

  localparam int NUM_BP = 3;
endpackage

// File: rtl/gpm_bp_regs.sv
module gpm_bp_regs #(
  parameter int PRIO_W     = 8,
  parameter int BP_W       = 3,
  parameter int MIN_BP     = 0,
  parameter int MIN_BP_NS  = 1,
  parameter bit VIRT_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [PRIO_W-1:0] rd_data,
  output logic [BP_W-1:0]   bp0,
  output logic [BP_W-1:0]   bp1s,
  output logic [BP_W-1:0]   bp1ns,
  output logic [1:0]        share
);
  import gpm_pkg::*;

  logic [BP_W-1:0] bp_q [NUM_BP];
  logic [1:0]      share_q;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    localparam int MINV = (i == int'(SEL_BP1NS)) ? MIN_BP_NS : MIN_BP;
    localparam int RSTV = VIRT_RESET ? ((i == int'(SEL_BP0)) ? MIN_BP : MIN_BP + 1) : MINV;
    localparam logic [BP_W-1:0] MIN_L = BP_W'(MINV);
    localparam logic [BP_W-1:0] RST_L = BP_W'(RSTV);
    logic [BP_W-1:0] low;
    assign low = wr_data[BP_W-1:0];
    always_ff @(posedge clk) begin
      if (rst) begin
        bp_q[i] <= RST_L;
      end else if (wr_en && wr_sel == 2'(i)) begin
        bp_q[i] <= (low < MIN_L) ? MIN_L : low;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      share_q <= 2'b00;
    end else if (wr_en && wr_sel == SEL_CTRL) begin
      share_q <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        SEL_BP0:   rd_data <= PRIO_W'(bp_q[0]);
        SEL_BP1S:  rd_data <= PRIO_W'(bp_q[1]);
        SEL_BP1NS: rd_data <= PRIO_W'(bp_q[2]);
        default:   rd_data <= PRIO_W'(share_q);
      endcase
    end
  end

  assign bp0   = bp_q[0];
  assign bp1s  = bp_q[1];
  assign bp1ns = bp_q[2];
  assign share = share_q;
endmodule

// File: rtl/gpm_mask_gen.sv
module gpm_mask_gen #(
  parameter int PRIO_W = 8,
  parameter int BP_W   = 3
) (
  input  logic [1:0]        grp,
  input  logic [BP_W-1:0]   bp0,
  input  logic [BP_W-1:0]   bp1s,
  input  logic [BP_W-1:0]   bp1ns,
  input  logic [1:0]        share,
  output logic [PRIO_W-1:0] mask
);
  import gpm_pkg::*;

  localparam int SH_W = BP_W + 1;
  localparam logic [PRIO_W-1:0] ONES = '1;

  logic [SH_W-1:0] shift;

  always_comb begin
    case (grp)
      GRP_G1S:  shift = share[0] ? SH_W'(bp0) + SH_W'(1) : SH_W'(bp1s) + SH_W'(1);
      GRP_G1NS: shift = share[1] ? SH_W'(bp0) + SH_W'(1) : SH_W'(bp1ns);
      default:  shift = SH_W'(bp0) + SH_W'(1);
    endcase
    mask = ONES << shift;
  end
endmodule

// File: rtl/gpm_preempt_cmp.sv
module gpm_preempt_cmp #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] pend,
  input  logic [PRIO_W-1:0] run,
  input  logic [PRIO_W-1:0] mask,
  output logic [PRIO_W-1:0] pend_m,
  output logic              wins
);
  logic [PRIO_W-1:0] run_m;
  assign pend_m = pend & mask;
  assign run_m  = run & mask;
  assign wins   = pend_m < run_m;
endmodule

// File: rtl/gpm_unit.sv
module gpm_unit #(
  parameter int PRIO_W     = 8,
  parameter int BP_W       = $clog2(PRIO_W),
  parameter int MIN_BP     = 0,
  parameter int MIN_BP_NS  = 1,
  parameter bit VIRT_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [PRIO_W-1:0] rd_data,
  input  logic [1:0]        lk_group,
  input  logic [PRIO_W-1:0] lk_prio,
  input  logic [PRIO_W-1:0] run_prio,
  output logic [PRIO_W-1:0] gp_mask,
  output logic [PRIO_W-1:0] gp_prio,
  output logic              preempt
);
  logic [BP_W-1:0]   bp0_w, bp1s_w, bp1ns_w;
  logic [1:0]        share_w;
  logic [PRIO_W-1:0] mask_w, pend_m_w;
  logic              wins_w;

  gpm_bp_regs #(
    .PRIO_W(PRIO_W), .BP_W(BP_W), .MIN_BP(MIN_BP),
    .MIN_BP_NS(MIN_BP_NS), .VIRT_RESET(VIRT_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .bp0(bp0_w), .bp1s(bp1s_w), .bp1ns(bp1ns_w), .share(share_w)
  );

  gpm_mask_gen #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_mask (
    .grp(lk_group), .bp0(bp0_w), .bp1s(bp1s_w), .bp1ns(bp1ns_w),
    .share(share_w), .mask(mask_w)
  );

  gpm_preempt_cmp #(.PRIO_W(PRIO_W)) u_cmp (
    .pend(lk_prio), .run(run_prio), .mask(mask_w),
    .pend_m(pend_m_w), .wins(wins_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gp_mask <= '0;
      gp_prio <= '0;
      preempt <= 1'b0;
    end else begin
      gp_mask <= mask_w;
      gp_prio <= pend_m_w;
      preempt <= wins_w;
    end
  end
endmodule

// File: rtl/gpm_unit_chk.sv
module gpm_unit_chk #(
  parameter int PRIO_W    = 8,
  parameter int BP_W      = 3,
  parameter int MIN_BP_NS = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [PRIO_W-1:0] wr_data,
  input logic [PRIO_W-1:0] rd_data,
  input logic [1:0]        lk_group,
  input logic [PRIO_W-1:0] lk_prio,
  input logic [PRIO_W-1:0] run_prio,
  input logic [PRIO_W-1:0] gp_mask,
  input logic              preempt,
  input logic [BP_W-1:0]   bp1ns,
  input logic [1:0]        share
);
  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (rst)
    ((~gp_mask) & ((~gp_mask) + 1'b1)) == '0); // R1

  AST_NS_TOPBIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lk_group) == 2'd2 && !$past(share[1])) |-> gp_mask[PRIO_W-1]); // R3

  AST_NS_FLOOR: assert property (@(posedge clk) disable iff (rst)
    bp1ns >= BP_W'(MIN_BP_NS)); // R5

  AST_CLAMP_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2 && wr_data[BP_W-1:0] == '0) |=> bp1ns == BP_W'(MIN_BP_NS)); // R5

  AST_PREEMPT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && preempt) |-> ($past(lk_prio) < $past(run_prio))); // R6

  AST_RD_ZEXT: assert property (@(posedge clk) disable iff (rst)
    rd_data[PRIO_W-1:BP_W] == '0); // R9
endmodule

bind gpm_unit gpm_unit_chk #(
  .PRIO_W(PRIO_W), .BP_W(BP_W), .MIN_BP_NS(MIN_BP_NS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_data(rd_data), .lk_group(lk_group), .lk_prio(lk_prio), .run_prio(run_prio),
  .gp_mask(gp_mask), .preempt(preempt), .bp1ns(bp1ns_w), .share(share_w)
);

// File: tb/gpm_unit_tb.sv
module gpm_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // fields: bp0[34:32] bpg[31:29] ctrl[28:27] grp[26:25] prio[24:17] run[16:9] mask[8:1] pre[0]
  localparam logic [34:0] VEC [NVEC] = '{
    {3'd0, 3'd0, 2'd0, 2'd0, 8'h41, 8'h42, 8'hFE, 1'b1},
    {3'd2, 3'd0, 2'd0, 2'd0, 8'h41, 8'h47, 8'hF8, 1'b0},
    {3'd7, 3'd0, 2'd0, 2'd0, 8'h00, 8'hFF, 8'h00, 1'b0},
    {3'd0, 3'd3, 2'd0, 2'd1, 8'h10, 8'h2F, 8'hF0, 1'b1},
    {3'd0, 3'd1, 2'd0, 2'd2, 8'h80, 8'h81, 8'hFE, 1'b0},
    {3'd0, 3'd7, 2'd0, 2'd2, 8'h7F, 8'h80, 8'h80, 1'b1},
    {3'd4, 3'd1, 2'd2, 2'd2, 8'h20, 8'h3F, 8'hE0, 1'b0},
    {3'd5, 3'd2, 2'd1, 2'd1, 8'h00, 8'h40, 8'hC0, 1'b1},
    {3'd5, 3'd2, 2'd2, 2'd1, 8'h08, 8'h10, 8'hF8, 1'b1},
    {3'd3, 3'd4, 2'd1, 2'd2, 8'h0F, 8'h10, 8'hF0, 1'b1},
    {3'd0, 3'd0, 2'd0, 2'd2, 8'h02, 8'h03, 8'hFE, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [1:0] lk_group = '0;
  logic [7:0] lk_prio = '0;
  logic [7:0] run_prio = '0;
  logic [7:0] rd_data, gp_mask, gp_prio, v_rd_data, v_mask, v_prio;
  logic       preempt, v_pre;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gpm_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .lk_group(lk_group), .lk_prio(lk_prio),
    .run_prio(run_prio), .gp_mask(gp_mask), .gp_prio(gp_prio), .preempt(preempt)
  );

  gpm_unit #(.VIRT_RESET(1'b1)) u_virt (
    .clk(clk), .rst(rst), .wr_en(1'b0), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(v_rd_data), .lk_group(lk_group), .lk_prio(lk_prio),
    .run_prio(run_prio), .gp_mask(v_mask), .gp_prio(v_prio), .preempt(v_pre)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_both(input logic [1:0] sel, output logic [7:0] d, output logic [7:0] vd);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    d = rd_data; vd = v_rd_data;
  endtask

  task automatic lookup(input logic [1:0] g, input logic [7:0] p, input logic [7:0] r);
    @(negedge clk);
    lk_group = g; lk_prio = p; run_prio = r;
    @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] d, vd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R7: reset values, physical and virtual profiles
    rd_both(2'd0, d, vd); chk("R7 bp0", d, 8'd0); chk("R7 virt bp0", vd, 8'd0);
    rd_both(2'd1, d, vd); chk("R7 bp1s", d, 8'd0); chk("R7 virt bp1s", vd, 8'd1);
    rd_both(2'd2, d, vd); chk("R7 bp1ns", d, 8'd1); chk("R7 virt bp1ns", vd, 8'd1);
    rd_both(2'd3, d, vd); chk("R7 ctrl", d, 8'd0);

    // Vector table: R1..R6
    for (int i = 0; i < NVEC; i++) begin
      logic [34:0] e;
      string tag;
      e = VEC[i];
      tag = (i < 3) ? "R1" : (i == 3) ? "R2" : (i < 6) ? "R3" : (i < 10) ? "R4" : "R5";
      wr(2'd0, {5'd0, e[34:32]});
      if (e[26:25] != 2'd0) wr(e[26:25], {5'd0, e[31:29]});
      wr(2'd3, {6'd0, e[28:27]});
      lookup(e[26:25], e[24:17], e[16:9]);
      chk($sformatf("%s mask vec %0d", tag, i), gp_mask, e[8:1]);
      chk($sformatf("R6 preempt vec %0d", i), {7'd0, preempt}, {7'd0, e[0]});
      chk($sformatf("R6 masked prio vec %0d", i), gp_prio, e[24:17] & e[8:1]);
    end

    // R1: unused group code 3 behaves like group 0
    wr(2'd3, 8'h03);
    wr(2'd0, 8'h06);
    lookup(2'd3, 8'h55, 8'h55);
    chk("R1 code3 mask", gp_mask, 8'h80);

    // R5: upper write bits dropped, clamp applied after truncation
    wr(2'd0, 8'hF9);
    rd_both(2'd0, d, vd); chk("R5 bp0 low bits", d, 8'd1);
    wr(2'd2, 8'h08);
    rd_both(2'd2, d, vd); chk("R5 bp1ns clamp", d, 8'd1);
    wr(2'd1, 8'h00);
    rd_both(2'd1, d, vd); chk("R5 bp1s zero kept", d, 8'd0);
    wr(2'd3, 8'hFE);
    rd_both(2'd3, d, vd); chk("R9 ctrl zext", d, 8'd2);

    // R8: write and lookup in the same cycle
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h07;
    lk_group = 2'd0; lk_prio = 8'h01; run_prio = 8'h02;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 old setting", gp_mask, 8'hFE);
    @(negedge clk);
    chk("R8 new setting", gp_mask, 8'h00);

    done = 1'b1;
    report();
  end
endmodule